// File: doc/BRIEF.md
# Paged Data-to-Program Window Translator

This block sits on a 16-bit data-space read port. For every read it decides where the read goes, using the effective address and a 10-bit read page register. Addresses in the lower half of the data space always go to data RAM. Addresses in the upper half are candidates for a paged 32-Kbyte window. Depending on the page value, the window points at extended data space or at program memory, or the read is refused with an address-error trap.

For a program-memory read, the block builds a 24-bit program address. It also picks one of two lanes of the 24-bit program word: the lower 16 bits, or the upper byte padded with zeros. It then formats the returned word for word-mode or byte-mode reads. Each request is decoded in the cycle it is presented. The route, the address, the lane and the trap are registered and appear one cycle later. The read data is formed in that same cycle from the word the memory returns.

Top module: `pgwin_xlate`

## Requirements
- R1: After reset the read page register holds 0x001, so a read at 0x8000 issued straight after reset is routed to extended data space. While no response is pending, `valid_o` and `trap_o` are low.
- R2: A read whose address bit 15 is 0 is routed to RAM (route code 0) for any page value, including 0x000, and never traps.
- R3: A read with address bit 15 set while the page register is 0x000 raises `trap_o` with route code 3. `prog_re_o` stays low for that read and the read data is 0.
- R4: A read with address bit 15 set and a page value from 0x001 to 0x1FF is routed to extended data space (route code 1) and returns `data_word_i`.
- R5: A read with address bit 15 set and a page value from 0x200 to 0x3FF is routed to program memory (route code 2) and raises `prog_re_o`. `prog_addr_o` is {0, page[7:0], address[14:0]}, so address bit 15 does not appear in it.
- R6: When page bits 9:8 are 2'b10, `lane_hi_o` is 0 and a word-mode read returns bits 15:0 of `prog_word_i`.
- R7: When page bits 9:8 are 2'b11, `lane_hi_o` is 1 and a word-mode read returns {8'h00, `prog_word_i`[23:16]}.
- R8: In byte mode, address bit 0 selects a byte of the selected 16-bit word: 0 takes bits 7:0 and 1 takes bits 15:8. The byte is zero-extended. On the upper-byte lane, address bit 0 = 1 therefore returns 0.
- R9: A page write applies to requests from the next cycle onward. A request presented in the same cycle as the write is decoded with the old page value.
- R10: Each request produces `valid_o` exactly one cycle later. A cycle with no request leaves `valid_o`, `trap_o` and `prog_re_o` low in the following cycle.
- R11: The block has no write path. `prog_re_o` rises only in the response cycle of a program-routed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| page_we_i | input | 1 | Write strobe for the read page register |
| page_wdata_i | input | 10 | New read page value |
| rd_req_i | input | 1 | Read request strobe |
| rd_addr_i | input | 16 | Effective data-space address |
| rd_byte_i | input | 1 | 1 = byte-mode read, 0 = word-mode read |
| prog_word_i | input | 24 | Program word returned for `prog_addr_o` |
| data_word_i | input | 16 | Word returned by RAM or extended data space |
| valid_o | output | 1 | Response cycle for the previous request |
| route_o | output | 2 | 0 RAM, 1 extended data, 2 program, 3 none/trap |
| trap_o | output | 1 | Address-error trap |
| prog_re_o | output | 1 | Program memory read enable |
| prog_addr_o | output | 24 | Program word address with byte select in bit 0 |
| lane_hi_o | output | 1 | 1 = upper-byte lane, 0 = low-word lane |
| rd_data_o | output | 16 | Formatted read data |

## Verification
The bench builds the block with its default parameters: a 16-bit data word, a 10-bit page register and a reset page of 0x001. With a 10-bit page, all 1024 page values can be swept in a few thousand cycles. The sweep reaches the zero-page trap, every extended-data page, and both program lanes with every low page byte in the program address. The 16-bit word makes both byte positions and the zero upper byte of the high lane directly observable at `rd_data_o`.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;
  typedef enum logic [1:0] {
    ROUTE_RAM  = 2'd0,
    ROUTE_EXT  = 2'd1,
    ROUTE_PROG = 2'd2,
    ROUTE_NONE = 2'd3
  } route_e;
endpackage

// File: rtl/pgwin_page_reg.sv
module pgwin_page_reg #(
  parameter int unsigned PAGE_W     = 10,
  parameter int unsigned RESET_PAGE = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] wdata_i,
  output logic [PAGE_W-1:0] page_o
);
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   page_q <= PAGE_W'(RESET_PAGE);
    else if (we_i) page_q <= wdata_i;
  end

  assign page_o = page_q;
endmodule

// File: rtl/pgwin_decode.sv
module pgwin_decode
  import pgwin_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned PAGE_W  = 10,
  localparam int unsigned PROG_AW = 1 + (PAGE_W - 2) + (DATA_W - 1)
) (
  input  logic [DATA_W-1:0]  addr_i,
  input  logic [PAGE_W-1:0]  page_i,
  output route_e             route_o,
  output logic               trap_o,
  output logic               lane_hi_o,
  output logic [PROG_AW-1:0] prog_addr_o
);
  logic win, page_zero, prog_page;

  assign win       = addr_i[DATA_W-1];
  assign page_zero = (page_i == '0);
  assign prog_page = page_i[PAGE_W-1];

  always_comb begin
    route_o = ROUTE_RAM;
    trap_o  = 1'b0;
    if (win) begin
      if (page_zero) begin
        route_o = ROUTE_NONE;
        trap_o  = 1'b1;
      end else if (prog_page) begin
        route_o = ROUTE_PROG;
      end else begin
        route_o = ROUTE_EXT;
      end
    end
  end

  assign lane_hi_o   = page_i[PAGE_W-2];
  assign prog_addr_o = {1'b0, page_i[PAGE_W-3:0], addr_i[DATA_W-2:0]};
endmodule

// File: rtl/pgwin_lane_fmt.sv
module pgwin_lane_fmt
  import pgwin_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  localparam int unsigned BYTE_W  = DATA_W / 2,
  localparam int unsigned PWORD_W = DATA_W + BYTE_W
) (
  input  route_e             route_i,
  input  logic               lane_hi_i,
  input  logic               byte_mode_i,
  input  logic               byte_sel_i,
  input  logic [PWORD_W-1:0] prog_word_i,
  input  logic [DATA_W-1:0]  data_word_i,
  output logic [DATA_W-1:0]  rd_data_o
);
  logic [DATA_W-1:0] word;

  always_comb begin
    unique case (route_i)
      ROUTE_RAM, ROUTE_EXT: word = data_word_i;
      ROUTE_PROG: word = lane_hi_i ? {{BYTE_W{1'b0}}, prog_word_i[PWORD_W-1:DATA_W]}
                                   : prog_word_i[DATA_W-1:0];
      default:    word = '0;
    endcase
  end

  always_comb begin
    if (!byte_mode_i)    rd_data_o = word;
    else if (byte_sel_i) rd_data_o = {{BYTE_W{1'b0}}, word[DATA_W-1:BYTE_W]};
    else                 rd_data_o = {{BYTE_W{1'b0}}, word[BYTE_W-1:0]};
  end
endmodule

// File: rtl/pgwin_xlate.sv
module pgwin_xlate
  import pgwin_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned PAGE_W     = 10,
  parameter int unsigned RESET_PAGE = 1,
  localparam int unsigned PROG_AW   = 1 + (PAGE_W - 2) + (DATA_W - 1),
  localparam int unsigned PWORD_W   = DATA_W + DATA_W / 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               page_we_i,
  input  logic [PAGE_W-1:0]  page_wdata_i,
  input  logic               rd_req_i,
  input  logic [DATA_W-1:0]  rd_addr_i,
  input  logic               rd_byte_i,
  input  logic [PWORD_W-1:0] prog_word_i,
  input  logic [DATA_W-1:0]  data_word_i,
  output logic               valid_o,
  output logic [1:0]         route_o,
  output logic               trap_o,
  output logic               prog_re_o,
  output logic [PROG_AW-1:0] prog_addr_o,
  output logic               lane_hi_o,
  output logic [DATA_W-1:0]  rd_data_o
);
  logic [PAGE_W-1:0]  page;
  route_e             dec_route;
  logic               dec_trap, dec_lane;
  logic [PROG_AW-1:0] dec_addr;

  logic               valid_q, trap_q, lane_q, byte_q, bsel_q;
  route_e             route_q;
  logic [PROG_AW-1:0] addr_q;

  pgwin_page_reg #(.PAGE_W(PAGE_W), .RESET_PAGE(RESET_PAGE)) u_page (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (page_we_i),
    .wdata_i (page_wdata_i),
    .page_o  (page)
  );

  pgwin_decode #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_dec (
    .addr_i      (rd_addr_i),
    .page_i      (page),
    .route_o     (dec_route),
    .trap_o      (dec_trap),
    .lane_hi_o   (dec_lane),
    .prog_addr_o (dec_addr)
  );

  // decode uses the page value held before this edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      route_q <= ROUTE_NONE;
      trap_q  <= 1'b0;
      lane_q  <= 1'b0;
      byte_q  <= 1'b0;
      bsel_q  <= 1'b0;
      addr_q  <= '0;
    end else begin
      valid_q <= rd_req_i;
      route_q <= rd_req_i ? dec_route : ROUTE_NONE;
      trap_q  <= rd_req_i & dec_trap;
      if (rd_req_i) begin
        lane_q <= dec_lane;
        byte_q <= rd_byte_i;
        bsel_q <= rd_addr_i[0];
        addr_q <= dec_addr;
      end
    end
  end

  pgwin_lane_fmt #(.DATA_W(DATA_W)) u_fmt (
    .route_i     (route_q),
    .lane_hi_i   (lane_q),
    .byte_mode_i (byte_q),
    .byte_sel_i  (bsel_q),
    .prog_word_i (prog_word_i),
    .data_word_i (data_word_i),
    .rd_data_o   (rd_data_o)
  );

  assign valid_o     = valid_q;
  assign route_o     = route_q;
  assign trap_o      = trap_q;
  assign prog_re_o   = valid_q && (route_q == ROUTE_PROG);
  assign prog_addr_o = addr_q;
  assign lane_hi_o   = lane_q;
endmodule

// File: rtl/pgwin_xlate_chk.sv
module pgwin_xlate_chk #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned PROG_AW = 24
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rd_req_i,
  input logic [DATA_W-1:0]  rd_addr_i,
  input logic               rd_byte_i,
  input logic               valid_o,
  input logic [1:0]         route_o,
  input logic               trap_o,
  input logic               prog_re_o,
  input logic [PROG_AW-1:0] prog_addr_o,
  input logic               lane_hi_o,
  input logic [DATA_W-1:0]  rd_data_o
);
  localparam int unsigned HB = DATA_W / 2;

  a_r2_low_half_ram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i && !rd_addr_i[DATA_W-1] |=> route_o == 2'd0 && !trap_o);

  a_r3_trap_blocks_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> valid_o && route_o == 2'd3 && !prog_re_o);

  a_r5_prog_addr_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_re_o |-> !prog_addr_o[PROG_AW-1] &&
                  prog_addr_o[DATA_W-2:0] == $past(rd_addr_i[DATA_W-2:0]));

  a_r7_hi_lane_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_re_o && lane_hi_o |-> rd_data_o[DATA_W-1:HB] == '0);

  a_r8_byte_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(rd_req_i && rd_byte_i) |-> rd_data_o[DATA_W-1:HB] == '0);

  a_r10_valid_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> valid_o);

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> !valid_o && !trap_o && !prog_re_o);

  a_r11_prog_only_windowed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_re_o |-> $past(rd_req_i && rd_addr_i[DATA_W-1]));
endmodule

bind pgwin_xlate pgwin_xlate_chk #(.DATA_W(DATA_W), .PROG_AW(PROG_AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_req_i    (rd_req_i),
  .rd_addr_i   (rd_addr_i),
  .rd_byte_i   (rd_byte_i),
  .valid_o     (valid_o),
  .route_o     (route_o),
  .trap_o      (trap_o),
  .prog_re_o   (prog_re_o),
  .prog_addr_o (prog_addr_o),
  .lane_hi_o   (lane_hi_o),
  .rd_data_o   (rd_data_o)
);

// File: tb/pgwin_xlate_test.sv
module pgwin_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        page_we = 1'b0;
  logic [9:0]  page_wd = '0;
  logic        rd_req = 1'b0;
  logic [15:0] rd_addr = '0;
  logic        rd_byte = 1'b0;
  logic [23:0] prog_word;
  logic [15:0] dword = 16'hA55A;
  logic        valid, trap, prog_re, lane_hi;
  logic [1:0]  route;
  logic [23:0] prog_addr;
  logic [15:0] rd_data;

  int checks = 0;
  int fails  = 0;
  logic [9:0] mpage = 10'h001;

  always #2 clk = ~clk;

  function automatic logic [23:0] mem(input logic [23:0] a);
    return {a[23:16] ^ a[7:0] ^ 8'h5A, a[15:0] ^ 16'hC3A5};
  endfunction

  assign prog_word = mem(prog_addr);

  pgwin_xlate uut (
    .clk_i(clk), .rst_ni(rst_n), .page_we_i(page_we), .page_wdata_i(page_wd),
    .rd_req_i(rd_req), .rd_addr_i(rd_addr), .rd_byte_i(rd_byte),
    .prog_word_i(prog_word), .data_word_i(dword),
    .valid_o(valid), .route_o(route), .trap_o(trap), .prog_re_o(prog_re),
    .prog_addr_o(prog_addr), .lane_hi_o(lane_hi), .rd_data_o(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_route(input logic [9:0] p, input logic [15:0] a);
    if (!a[15])       return 2'd0;
    if (p == 10'h000) return 2'd3;
    if (p[9])         return 2'd2;
    return 2'd1;
  endfunction

  function automatic logic [15:0] exp_data(input logic [9:0] p, input logic [15:0] a,
                                           input logic b);
    logic [15:0] w;
    logic [23:0] pw;
    case (exp_route(p, a))
      2'd0, 2'd1: w = dword;
      2'd2: begin
        pw = mem({1'b0, p[7:0], a[14:0]});
        w  = p[8] ? {8'h00, pw[23:16]} : pw[15:0];
      end
      default: w = 16'h0000;
    endcase
    if (!b) return w;
    return a[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  // one cycle: optional request and/or page write; checks response when req
  task automatic xact(input string tag, input logic req, input logic [15:0] a,
                      input logic b, input logic we, input logic [9:0] wd);
    logic [1:0] er;
    @(negedge clk);
    rd_req = req; rd_addr = a; rd_byte = b; page_we = we; page_wd = wd;
    @(posedge clk);
    @(negedge clk);
    rd_req = 1'b0; page_we = 1'b0;
    if (req) begin
      er = exp_route(mpage, a);
      chk({tag, " valid"}, 32'(valid), 32'd1);
      chk({tag, " route"}, 32'(route), 32'(er));
      chk({tag, " trap"}, 32'(trap), 32'(er == 2'd3));
      chk({tag, " prog_re"}, 32'(prog_re), 32'(er == 2'd2));
      chk({tag, " data"}, 32'(rd_data), 32'(exp_data(mpage, a, b)));
      if (er == 2'd2) begin
        chk({tag, " addr"}, 32'(prog_addr), 32'({1'b0, mpage[7:0], a[14:0]}));
        chk({tag, " lane"}, 32'(lane_hi), 32'(mpage[8]));
      end
    end else begin
      chk({tag, " idle valid"}, 32'(valid), 32'd0);
      chk({tag, " idle trap"}, 32'(trap), 32'd0);
      chk({tag, " idle prog_re"}, 32'(prog_re), 32'd0);
    end
    if (we) mpage = wd;
  endtask

  task automatic set_page(input logic [9:0] p);
    xact("R10", 1'b0, 16'h0000, 1'b0, 1'b1, p);
  endtask

  task automatic t_reset;
    chk("R1 valid after reset", 32'(valid), 32'd0);
    chk("R1 trap after reset", 32'(trap), 32'd0);
    xact("R1", 1'b1, 16'h8000, 1'b0, 1'b0, '0);
    chk("R1 ext route", 32'(route), 32'd1);
  endtask

  task automatic t_low_half;
    set_page(10'h000);
    xact("R2 page0", 1'b1, 16'h1234, 1'b0, 1'b0, '0);
    set_page(10'h2A2);
    xact("R2 prog page", 1'b1, 16'h7FFF, 1'b0, 1'b0, '0);
    set_page(10'h3FF);
    xact("R2 hi page", 1'b1, 16'h0001, 1'b1, 1'b0, '0);
  endtask

  task automatic t_trap;
    set_page(10'h000);
    xact("R3", 1'b1, 16'h8000, 1'b0, 1'b0, '0);
    chk("R3 route none", 32'(route), 32'd3);
    chk("R3 data zero", 32'(rd_data), 32'd0);
    xact("R10 after trap", 1'b0, 16'h8000, 1'b0, 1'b0, '0);
  endtask

  task automatic t_ext;
    dword = 16'h1E2D;
    set_page(10'h001);
    xact("R4 low", 1'b1, 16'hFFFE, 1'b0, 1'b0, '0);
    set_page(10'h1FF);
    xact("R4 top", 1'b1, 16'h9000, 1'b0, 1'b0, '0);
    chk("R4 data", 32'(rd_data), 32'h1E2D);
  endtask

  task automatic t_prog;
    set_page(10'h2A2);
    xact("R5", 1'b1, 16'h8000, 1'b0, 1'b0, '0);
    chk("R5 addr 0x510000", 32'(prog_addr), 32'h510000);
    xact("R6", 1'b1, 16'hFFFE, 1'b0, 1'b0, '0);
    chk("R6 low word", 32'(rd_data), 32'(mem(24'h517FFE) & 24'h00FFFF));
    set_page(10'h3A2);
    xact("R7", 1'b1, 16'h8002, 1'b0, 1'b0, '0);
    chk("R7 lane hi", 32'(lane_hi), 32'd1);
    chk("R7 upper byte", 32'(rd_data), 32'({8'h00, mem(24'h510002) >> 16}));
  endtask

  task automatic t_byte;
    dword = 16'hBEEF;
    set_page(10'h2A2);
    xact("R8 lo b0", 1'b1, 16'h8010, 1'b1, 1'b0, '0);
    xact("R8 lo b1", 1'b1, 16'h8011, 1'b1, 1'b0, '0);
    set_page(10'h3A2);
    xact("R8 hi b0", 1'b1, 16'h8010, 1'b1, 1'b0, '0);
    xact("R8 hi b1", 1'b1, 16'h8011, 1'b1, 1'b0, '0);
    chk("R8 phantom byte", 32'(rd_data), 32'd0);
    xact("R8 ram b1", 1'b1, 16'h0003, 1'b1, 1'b0, '0);
    chk("R8 ram byte", 32'(rd_data), 32'h00BE);
  endtask

  task automatic t_page_timing;
    set_page(10'h001);
    xact("R9 old page", 1'b1, 16'h8004, 1'b0, 1'b1, 10'h2A2);
    chk("R9 same-cycle write ignored", 32'(route), 32'd1);
    xact("R9 new page", 1'b1, 16'h8004, 1'b0, 1'b0, '0);
    chk("R9 new page used", 32'(route), 32'd2);
  endtask

  task automatic t_sweep;
    for (int p = 0; p < 1024; p++) begin
      set_page(10'(p));
      xact("R11 sweep", 1'b1, 16'hC001, 1'b0, 1'b0, '0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_low_half();
    t_trap();
    t_ext();
    t_prog();
    t_byte();
    t_page_timing();
    t_sweep();
    xact("R10 idle", 1'b0, 16'hFFFF, 1'b0, 1'b0, '0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule